// File: doc/BRIEF.md
# Single-Sector PIO Read Sequencer for an 8-bit ATA Register Bus

This block is a bus master for a flash card attached through the ATA task-file register bus in 8-bit programmed-I/O mode. When it gets a start pulse, it first switches the card to 8-bit transfers. It then loads a 28-bit logical block address and the read-sector command, and polls the status register until the card is no longer busy. After that it drains the data register and streams the sector bytes out on a valid/ready byte interface.

The card side consists of the following signals:
- a 3-bit register select;
- an active-low chip select;
- separate active-low read and write strobes;
- a data bus split into an input bus, an output bus and an output-enable.

Every register access has the same fixed shape: one setup clock with select and address stable, a strobe held low for `STROBE_CLKS` clocks, one hold clock, and at least one idle clock before the next access. The sequencer reads the data register until the card drops its data-request bit. It forwards at most `SECTOR_BYTES` of those bytes and silently drops any surplus. If the card reports an error, the sequencer finishes early and flags it.

Top module: `cfrd_seq`

## Requirements
- R1: While reset is active and immediately after it, `bus_cs_n`, `bus_rd_n` and `bus_wr_n` are high, and `out_valid`, `done` and `err` are low.
- R2: After `start`, the first three bus writes are, in order: register 6 ← 0xE0, register 1 ← 0x01, register 7 ← 0xEF (select 8-bit transfers).
- R3: After the card is idle again, the next six writes are, in order: register 3 ← lba[7:0], register 4 ← lba[15:8], register 5 ← lba[23:16], register 6 ← 0xE0 | lba[27:24], register 2 ← 0x01, register 7 ← 0x20 (read one sector).
- R4: After each write to register 7, the block only reads register 7 until a read returns bit 7 (busy) equal to 0. It makes no write and no data-register read in that period.
- R5: In every access, chip select is low and the address is held stable from the clock before the strobe falls until the clock after it rises. Each strobe is low for exactly `STROBE_CLKS` clocks (minimum 2).
- R6: The bytes read from register 0 are emitted in read order, one per handshake, up to `SECTOR_BYTES` of them.
- R7: The block keeps reading register 0 while the status bit 3 (data request) is 1 and busy is 0. Bytes beyond `SECTOR_BYTES` are read and discarded. A card that drops data request early ends the transfer with fewer bytes.
- R8: If status bit 0 (error) is 1 once busy has cleared, the block sets `err` together with `done` and emits no further bytes. No write follows an error seen after the set-features command.
- R9: While `out_valid` is high and `out_ready` is low, `out_valid` and `out_data` hold. No bus access starts while a byte is pending.
- R10: `done` (and `err` when set) stays high after the transfer ends and is cleared on the clock that accepts the next `start`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a one-sector read (accepted when idle) |
| lba | input | 28 | Logical block address, sampled with `start` |
| bus_addr | output | 3 | Task-file register select |
| bus_cs_n | output | 1 | Active-low chip select |
| bus_rd_n | output | 1 | Active-low read strobe |
| bus_wr_n | output | 1 | Active-low write strobe |
| bus_dout | output | 8 | Write data to the card |
| bus_dout_en | output | 1 | Drive enable for `bus_dout` |
| bus_din | input | 8 | Read data from the card |
| out_valid | output | 1 | Sector byte available |
| out_ready | input | 1 | Consumer accepts the byte |
| out_data | output | 8 | Sector byte |
| done | output | 1 | Transfer finished |
| err | output | 1 | Card reported an error |

## Verification
All outputs are registered.
- `done` clears one clock after `start` is sampled, so the bench checks it at the next falling edge.
- Read data is captured on the last strobe clock, and the card model updates its pointer, busy timer and data-request flag only at the clock after the strobe rises. No card response can reach the sequencer before the next access samples it.
- Strobe width, setup and release are measured clock by clock against `STROBE_CLKS` as every access completes.
- Bytes are taken at falling edges only when valid and ready are both high, and compared with the arithmetic pattern the card model serves.
- Sector completion takes a data-dependent number of clocks, so the bench waits for `done` within a bounded window and then compares the write log, byte counts and flags.

// File: rtl/cfrd_pkg.sv
package cfrd_pkg;

  // task-file register offsets
  localparam logic [2:0] REG_DATA = 3'd0;
  localparam logic [2:0] REG_FEAT = 3'd1;
  localparam logic [2:0] REG_SCNT = 3'd2;
  localparam logic [2:0] REG_LBA0 = 3'd3;
  localparam logic [2:0] REG_LBA1 = 3'd4;
  localparam logic [2:0] REG_LBA2 = 3'd5;
  localparam logic [2:0] REG_DEV  = 3'd6;
  localparam logic [2:0] REG_CMD  = 3'd7;   // status on read

  // status bit positions
  localparam int ST_BUSY = 7;
  localparam int ST_DRQ  = 3;
  localparam int ST_ERR  = 0;

  localparam logic [7:0] DEV_BASE    = 8'hE0;
  localparam logic [7:0] FEAT_8BIT   = 8'h01;
  localparam logic [7:0] CMD_SETFEAT = 8'hEF;
  localparam logic [7:0] CMD_RDSEC   = 8'h20;

  localparam logic [3:0] STEP_FEAT_CMD = 4'd2;
  localparam logic [3:0] STEP_READ_CMD = 4'd8;

  typedef struct packed {
    logic       we;
    logic [2:0] addr;
    logic [7:0] wdata;
  } acc_t;

  typedef enum logic [2:0] {
    C_IDLE, C_WR, C_POLL, C_DST, C_DDAT, C_EMIT
  } ctrl_st_t;

  function automatic logic [7:0] dev_byte(input logic [27:0] l);
    return DEV_BASE | {4'h0, l[27:24]};
  endfunction

  // write program: index -> register write
  function automatic acc_t prog_step(input logic [3:0] s, input logic [27:0] l);
    acc_t a;
    a.we = 1'b1;
    case (s)
      4'd0:    begin a.addr = REG_DEV;  a.wdata = DEV_BASE;    end
      4'd1:    begin a.addr = REG_FEAT; a.wdata = FEAT_8BIT;   end
      4'd2:    begin a.addr = REG_CMD;  a.wdata = CMD_SETFEAT; end
      4'd3:    begin a.addr = REG_LBA0; a.wdata = l[7:0];      end
      4'd4:    begin a.addr = REG_LBA1; a.wdata = l[15:8];     end
      4'd5:    begin a.addr = REG_LBA2; a.wdata = l[23:16];    end
      4'd6:    begin a.addr = REG_DEV;  a.wdata = dev_byte(l); end
      4'd7:    begin a.addr = REG_SCNT; a.wdata = 8'h01;       end
      4'd8:    begin a.addr = REG_CMD;  a.wdata = CMD_RDSEC;   end
      default: begin a.we = 1'b0; a.addr = REG_CMD; a.wdata = 8'h00; end
    endcase
    return a;
  endfunction

endpackage

// File: rtl/cfrd_busio.sv
module cfrd_busio
  import cfrd_pkg::*;
#(
  parameter int STRB_CLKS = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       acc_req,
  input  acc_t       acc_in,
  output logic       acc_ack,
  output logic [7:0] acc_rdata,
  output logic [2:0] bus_addr,
  output logic       bus_cs_n,
  output logic       bus_rd_n,
  output logic       bus_wr_n,
  output logic [7:0] bus_dout,
  output logic       bus_dout_en,
  input  logic [7:0] bus_din
);
  localparam int SW = (STRB_CLKS < 2) ? 2 : STRB_CLKS;
  localparam int CW = $clog2(SW + 1);

  typedef enum logic [1:0] {B_IDLE, B_SETUP, B_STRB, B_HOLD} bst_t;

  bst_t          st;
  logic [CW-1:0] cnt;
  acc_t          cur;

  wire strb_last = (st == B_STRB) && (cnt == CW'(SW - 1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st        <= B_IDLE;
      cnt       <= '0;
      cur       <= '0;
      acc_rdata <= 8'h00;
    end else begin
      case (st)
        B_IDLE:  if (acc_req) begin cur <= acc_in; st <= B_SETUP; end
        B_SETUP: begin st <= B_STRB; cnt <= '0; end
        B_STRB:  begin
          if (strb_last) begin
            st <= B_HOLD;
            if (!cur.we) acc_rdata <= bus_din;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        default: st <= B_IDLE;
      endcase
    end
  end

  assign acc_ack     = (st == B_HOLD);
  assign bus_cs_n    = (st == B_IDLE);
  assign bus_rd_n    = !((st == B_STRB) && !cur.we);
  assign bus_wr_n    = !((st == B_STRB) && cur.we);
  assign bus_addr    = cur.addr;
  assign bus_dout    = cur.wdata;
  assign bus_dout_en = cur.we && (st != B_IDLE);

  // R5
  strobe_setup_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(bus_rd_n) || $fell(bus_wr_n)) |-> $past(!bus_cs_n));
  // R5
  strobe_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(bus_rd_n) || $rose(bus_wr_n)) |-> !bus_cs_n);
  // R5
  addr_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!bus_cs_n && $past(!bus_cs_n)) |-> $stable(bus_addr));
  // R5
  launch_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    acc_req |-> bus_cs_n);

endmodule

// File: rtl/cfrd_ctrl.sv
module cfrd_ctrl
  import cfrd_pkg::*;
#(
  parameter int SECTOR_BYTES = 512
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  input  logic [27:0] lba,
  output logic        acc_req,
  output acc_t        acc_in,
  input  logic        acc_ack,
  input  logic [7:0]  acc_rdata,
  output logic        out_valid,
  input  logic        out_ready,
  output logic [7:0]  out_data,
  output logic        done,
  output logic        err
);
  localparam int CNTW = $clog2(SECTOR_BYTES + 1);

  ctrl_st_t        st;
  logic [3:0]      step;
  logic            phase;     // 0: after set-features, 1: after read command
  logic            waiting;
  logic [27:0]     lba_q;
  logic [CNTW-1:0] cnt;

  // decoded status events
  wire stat_busy = acc_rdata[ST_BUSY];
  wire stat_drq  = acc_rdata[ST_DRQ];
  wire stat_err  = acc_rdata[ST_ERR];
  wire room      = (cnt < CNTW'(SECTOR_BYTES));
  wire in_access = (st == C_WR) || (st == C_POLL) || (st == C_DST) || (st == C_DDAT);

  assign acc_req = in_access && !waiting;

  always_comb begin
    case (st)
      C_WR:    acc_in = prog_step(step, lba_q);
      C_DDAT:  acc_in = '{we: 1'b0, addr: REG_DATA, wdata: 8'h00};
      default: acc_in = '{we: 1'b0, addr: REG_CMD,  wdata: 8'h00};
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st        <= C_IDLE;
      step      <= 4'd0;
      phase     <= 1'b0;
      waiting   <= 1'b0;
      lba_q     <= '0;
      cnt       <= '0;
      out_valid <= 1'b0;
      out_data  <= 8'h00;
      done      <= 1'b0;
      err       <= 1'b0;
    end else begin
      if (acc_req) waiting <= 1'b1;
      case (st)
        C_IDLE: if (start) begin
          lba_q <= lba;
          step  <= 4'd0;
          phase <= 1'b0;
          cnt   <= '0;
          done  <= 1'b0;
          err   <= 1'b0;
          st    <= C_WR;
        end
        C_WR: if (acc_ack) begin
          waiting <= 1'b0;
          if (step == STEP_FEAT_CMD) begin
            phase <= 1'b0; st <= C_POLL;
          end else if (step == STEP_READ_CMD) begin
            phase <= 1'b1; st <= C_POLL;
          end
          step <= step + 4'd1;
        end
        C_POLL: if (acc_ack) begin
          waiting <= 1'b0;
          if (!stat_busy) begin
            if (stat_err) begin
              done <= 1'b1; err <= 1'b1; st <= C_IDLE;
            end else if (!phase) begin
              st <= C_WR;
            end else begin
              st <= C_DST;
            end
          end
        end
        C_DST: if (acc_ack) begin
          waiting <= 1'b0;
          if (!stat_busy) begin
            if (stat_err) begin
              done <= 1'b1; err <= 1'b1; st <= C_IDLE;
            end else if (!stat_drq) begin
              done <= 1'b1; st <= C_IDLE;
            end else begin
              st <= C_DDAT;
            end
          end
        end
        C_DDAT: if (acc_ack) begin
          waiting <= 1'b0;
          if (room) begin
            out_data  <= acc_rdata;
            out_valid <= 1'b1;
            st        <= C_EMIT;
          end else begin
            st <= C_DST;
          end
        end
        C_EMIT: if (out_ready) begin
          out_valid <= 1'b0;
          cnt       <= cnt + 1'b1;
          st        <= C_DST;
        end
        default: st <= C_IDLE;
      endcase
    end
  end

  // R9
  hold_byte_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));
  // R9
  no_launch_pending_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> !acc_req);
  // R8
  err_with_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> done);
  // R6
  byte_limit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CNTW'(SECTOR_BYTES));
  // R10
  done_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !start) |=> done);

endmodule

// File: rtl/cfrd_seq.sv
module cfrd_seq
  import cfrd_pkg::*;
#(
  parameter int STROBE_CLKS  = 2,
  parameter int SECTOR_BYTES = 512
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  input  logic [27:0] lba,
  output logic [2:0]  bus_addr,
  output logic        bus_cs_n,
  output logic        bus_rd_n,
  output logic        bus_wr_n,
  output logic [7:0]  bus_dout,
  output logic        bus_dout_en,
  input  logic [7:0]  bus_din,
  output logic        out_valid,
  input  logic        out_ready,
  output logic [7:0]  out_data,
  output logic        done,
  output logic        err
);
  logic       acc_req;
  acc_t       acc_in;
  logic       acc_ack;
  logic [7:0] acc_rdata;

  cfrd_ctrl #(.SECTOR_BYTES(SECTOR_BYTES)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .start(start), .lba(lba),
    .acc_req(acc_req), .acc_in(acc_in), .acc_ack(acc_ack), .acc_rdata(acc_rdata),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
    .done(done), .err(err)
  );

  cfrd_busio #(.STRB_CLKS(STROBE_CLKS)) u_bus (
    .clk(clk), .rst_n(rst_n),
    .acc_req(acc_req), .acc_in(acc_in), .acc_ack(acc_ack), .acc_rdata(acc_rdata),
    .bus_addr(bus_addr), .bus_cs_n(bus_cs_n), .bus_rd_n(bus_rd_n), .bus_wr_n(bus_wr_n),
    .bus_dout(bus_dout), .bus_dout_en(bus_dout_en), .bus_din(bus_din)
  );

  // R5
  strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(!bus_rd_n && !bus_wr_n));

endmodule

// File: tb/tb_cfrd_seq.sv
module tb_cfrd_seq;
  localparam int SB    = 3;
  localparam int SECT  = 512;
  localparam int BUSYT = 20;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [27:0] lba = '0;
  logic [2:0] bus_addr;
  logic bus_cs_n, bus_rd_n, bus_wr_n, bus_dout_en;
  logic [7:0] bus_dout, bus_din, out_data;
  logic out_valid, done, err;
  logic out_ready = 1'b1;

  always #4 clk = ~clk;

  cfrd_seq #(.STROBE_CLKS(SB), .SECTOR_BYTES(SECT)) dut (
    .clk(clk), .rst_n(rst_n), .start(start), .lba(lba),
    .bus_addr(bus_addr), .bus_cs_n(bus_cs_n), .bus_rd_n(bus_rd_n), .bus_wr_n(bus_wr_n),
    .bus_dout(bus_dout), .bus_dout_en(bus_dout_en), .bus_din(bus_din),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
    .done(done), .err(err)
  );

  int checks = 0;
  int errors = 0;

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic logic [7:0] pat(input logic [27:0] l, input int i);
    return 8'(int'(l[7:0]) + i * 13 + (i >> 8));
  endfunction

  // card configuration (written by the stimulus only)
  logic [27:0] cur_lba = '0;
  int supply = 0;
  int err_mode = 0;   // 0 none, 1 on set-features, 2 on read command
  logic card_rst = 1'b0;
  int ready_mode = 0;

  // card state
  int busy = 0, ptr = 0, nw = 0;
  bit drq = 0, errb = 0;
  logic [2:0] wla[0:15];
  logic [7:0] wld[0:15];
  int v_width = 0, v_setup = 0, v_rel = 0, v_addr = 0, v_busy = 0, v_pend = 0;
  int lowc = 0;
  logic prev_low = 1'b0, prev_cs = 1'b1, prev_rd_low = 1'b0, prev_wr_low = 1'b0;
  logic [2:0] prev_addr = 3'd0;

  wire [7:0] status = {busy > 0, 3'b000, drq && busy == 0, 2'b00, errb && busy == 0};
  assign bus_din = (bus_addr == 3'd0) ? pat(cur_lba, ptr) :
                   (bus_addr == 3'd7) ? status : 8'h00;

  wire strb_low = !bus_rd_n || !bus_wr_n;

  always @(posedge clk) begin
    if (card_rst) begin
      busy <= 0; ptr <= 0; nw <= 0; drq <= 0; errb <= 0;
    end else if (rst_n) begin
      if (busy > 0) busy <= busy - 1;
      // R5 strobe shape
      if (strb_low) lowc <= lowc + 1;
      else if (prev_low) begin
        if (lowc != SB) v_width <= v_width + 1;
        lowc <= 0;
      end
      if (strb_low && !prev_low && prev_cs) v_setup <= v_setup + 1;
      if (!strb_low && prev_low && bus_cs_n) v_rel <= v_rel + 1;
      if (!bus_cs_n && !prev_cs && bus_addr != prev_addr) v_addr <= v_addr + 1;
      // R9 no access while byte pending
      if (!bus_cs_n && out_valid) v_pend <= v_pend + 1;
      // write completed
      if (prev_wr_low && bus_wr_n) begin
        if (busy > 0) v_busy <= v_busy + 1;
        if (nw < 16) begin wla[nw] <= bus_addr; wld[nw] <= bus_dout; end
        nw <= nw + 1;
        if (bus_addr == 3'd7 && bus_dout == 8'hEF) begin
          busy <= BUSYT; errb <= (err_mode == 1); drq <= 0;
        end else if (bus_addr == 3'd7 && bus_dout == 8'h20) begin
          busy <= BUSYT; errb <= (err_mode == 2);
          drq <= (err_mode != 2) && (supply > 0); ptr <= 0;
        end
      end
      // read completed
      if (prev_rd_low && bus_rd_n) begin
        if (busy > 0 && bus_addr != 3'd7) v_busy <= v_busy + 1;
        if (bus_addr == 3'd0) begin
          ptr <= ptr + 1;
          if (ptr + 1 >= supply) drq <= 0;
        end
      end
    end
    prev_low    <= strb_low;
    prev_cs     <= bus_cs_n;
    prev_addr   <= bus_addr;
    prev_rd_low <= !bus_rd_n;
    prev_wr_low <= !bus_wr_n;
  end

  // consumer readiness
  int rcyc = 0;
  always @(posedge clk) begin
    rcyc <= rcyc + 1;
    out_ready <= (ready_mode == 0) ? 1'b1 : ((rcyc % 3) == 0);
  end

  // byte collector
  int nb = 0, mism = 0;
  always @(negedge clk) begin
    if (card_rst) begin
      nb <= 0; mism <= 0;
    end else if (out_valid && out_ready) begin
      if (out_data != pat(cur_lba, nb)) mism <= mism + 1;
      nb <= nb + 1;
    end
  end

  function automatic logic [10:0] exp_w(input int k, input logic [27:0] l);
    case (k)
      0: return {3'd6, 8'hE0};
      1: return {3'd1, 8'h01};
      2: return {3'd7, 8'hEF};
      3: return {3'd3, l[7:0]};
      4: return {3'd4, l[15:8]};
      5: return {3'd5, l[23:16]};
      6: return {3'd6, 8'hE0 | {4'h0, l[27:24]}};
      7: return {3'd2, 8'h01};
      default: return {3'd7, 8'h20};
    endcase
  endfunction

  task automatic run(input logic [27:0] l, input int sup, input int em, input int rm,
                     input int exp_nw, input int exp_nb, input bit exp_err, input string tag);
    @(negedge clk);
    card_rst = 1'b1; cur_lba = l; supply = sup; err_mode = em; ready_mode = rm; lba = l;
    @(negedge clk);
    card_rst = 1'b0; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(done == 1'b0, "R10", {tag, " done cleared by start"}, int'(done), 0);
    for (int i = 0; i < 30000 && !done; i++) @(negedge clk);
    repeat (4) @(negedge clk);
    chk(done == 1'b1, "R10", {tag, " done"}, int'(done), 1);
    chk(err == exp_err, "R8", {tag, " err flag"}, int'(err), int'(exp_err));
    chk(nw == exp_nw, "R2", {tag, " write count"}, nw, exp_nw);
    for (int k = 0; k < exp_nw && k < nw; k++)
      chk({wla[k], wld[k]} == exp_w(k, l), (k < 3) ? "R2" : "R3",
          {tag, " write entry"}, int'({wla[k], wld[k]}), int'(exp_w(k, l)));
    chk(nb == exp_nb, "R6", {tag, " bytes emitted"}, nb, exp_nb);
    chk(mism == 0, "R6", {tag, " byte values"}, mism, 0);
    if (em == 0) chk(ptr == sup, "R7", {tag, " bytes drained"}, ptr, sup);
    chk(done == 1'b1, "R10", {tag, " done held"}, int'(done), 1);
  endtask

  int cyc = 0;
  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 190000) begin
      errors++; checks++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 190000);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(bus_cs_n === 1'b1, "R1", "cs_n in reset", int'(bus_cs_n), 1);
    chk(bus_rd_n === 1'b1 && bus_wr_n === 1'b1, "R1", "strobes in reset", int'({bus_rd_n, bus_wr_n}), 3);
    chk(out_valid === 1'b0 && done === 1'b0 && err === 1'b0, "R1", "flags in reset",
        int'({out_valid, done, err}), 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk(bus_cs_n === 1'b1 && done === 1'b0, "R1", "idle after reset", int'({bus_cs_n, done}), 2);

    run(28'h1234567, 512, 0, 0, 9, 512, 1'b0, "full");
    run(28'hABCDEF5, 515, 0, 1, 9, 512, 1'b0, "surplus+backpressure");
    run(28'h0000001, 200, 0, 1, 9, 200, 1'b0, "short");
    run(28'h7654321, 512, 2, 0, 9, 0, 1'b1, "read-error");
    run(28'h0FFFFFF, 512, 1, 0, 3, 0, 1'b1, "feature-error");
    run(28'hF00000A, 512, 0, 0, 9, 512, 1'b0, "after-error");

    chk(v_width == 0, "R5", "strobe width", v_width, 0);
    chk(v_setup == 0, "R5", "select before strobe", v_setup, 0);
    chk(v_rel == 0, "R5", "select after strobe", v_rel, 0);
    chk(v_addr == 0, "R5", "address stable", v_addr, 0);
    chk(v_busy == 0, "R4", "access while busy", v_busy, 0);
    chk(v_pend == 0, "R9", "access while byte pending", v_pend, 0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule